// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block sits in the address path of a memory management unit and turns a 14-bit virtual address into a 12-bit physical address. Pages are 64 bytes. The low 6 address bits are the page offset and pass through unchanged. The upper 8 bits are the virtual page number (VPN). The VPN selects one of 4 sets through its 2 low bits, and the remaining 6 bits are compared as a tag against the 4 ways of that set. Each entry stores a physical page number (PPN) together with read and write rights. These rights are checked against the kind of access while the lookup happens.

A lookup that finds no matching entry raises a miss flag and keeps the request. The requester then walks the page table and delivers the translation on a refill port. The block installs the translation and finishes the held request. A refill may also arrive when no miss is outstanding. In that case it only installs the entry. A flush input drops every translation at once.

Top module: `tlb_xlate`

## Requirements
- R1: The physical address is the 6-bit PPN of the matching entry placed above the untouched low 6 bits of the virtual address. The set is VA[7:6] and the tag is VA[13:8]. For example, looking up VA 0x03D4 against an entry with VPN 0x0F and PPN 0x0D gives PA 0x354.
- R2: A request accepted while no miss is outstanding is resolved on the clock edge that samples it. `resp_done` or `resp_miss` is high for the cycle that follows.
- R3: A lookup hits only on a valid entry of the indexed set whose tag equals VA[13:8]. Otherwise `resp_miss` rises and `resp_done` stays low. At most one way of a set matches.
- R4: A read needs the entry's read right (`refill_rd`), and a write (`req_write`=1) needs its write right (`refill_wr`). A hit that lacks the right gives `resp_done`=1 with `resp_fault`=1 and `resp_pa`=0.
- R5: While `resp_miss` is high, requests are ignored and the flag stays up. A refill clears the flag on its accepting edge. The held request is then resolved on the next edge, against the table that now holds the refill.
- R6: A refill writes into the set named by its VPN's 2 low bits. It uses the way already holding that VPN if there is one. Otherwise it uses the lowest-numbered invalid way. When every way is valid, it uses the way given by that set's round-robin pointer. The pointer starts at way 0 and advances by one each time it is used.
- R7: A flush invalidates every entry on one edge. A refill in the same cycle as a flush is dropped, and an outstanding miss stays outstanding.
- R8: After reset, `resp_done`, `resp_fault`, `resp_miss` and `resp_pa` are 0 and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_va | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| resp_done | output | 1 | One-cycle pulse: translation finished (hit or fault) |
| resp_fault | output | 1 | With resp_done: access denied by the entry's rights |
| resp_pa | output | 12 | With resp_done and no fault: physical address |
| resp_miss | output | 1 | Level: a request waits for a refill |
| refill_valid | input | 1 | Install a translation |
| refill_vpn | input | 8 | VPN of the translation |
| refill_ppn | input | 6 | PPN of the translation |
| refill_rd | input | 1 | Read right of the translation |
| refill_wr | input | 1 | Write right of the translation |

## Verification
A request made while the block is idle is answered one edge later. The bench drives each request for a single cycle and reads `resp_done`, `resp_fault`, `resp_pa` and `resp_miss` at the falling edge right after the sampling edge. After a refill, two results are due at different times. The miss flag must already be low at the first falling edge. The replayed answer is due one edge later, so the bench checks them in those two separate cycles. Requests made during a miss are checked on the following edges to confirm that they give no answer at all.

// File: rtl/tlb_pkg.sv
// Shared types for the translation buffer.
// Assumes: nothing beyond standard SystemVerilog.
package tlb_pkg;

    // Access rights held per entry.
    typedef struct packed {
        logic rd;
        logic wr;
    } tlb_perm_t;

    // Request controller states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_REPLAY = 2'd2
    } tlb_state_e;

endpackage

// File: rtl/tlb_way_pick.sv
// Chooses the way a refill writes within one set. A way already holding
// the VPN comes first, then the lowest invalid way, then the round-robin way.
// Assumes: WAYS is a power of two; at most one bit of match_i is set.
module tlb_way_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAYS-1:0]  match_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             use_rr_o
);

    logic [WAY_W-1:0] match_way;
    logic [WAY_W-1:0] free_way;
    logic             any_match;
    logic             any_free;

    // Priority scan: walking downward leaves the lowest index standing.
    always_comb begin
        match_way = '0;
        free_way  = '0;
        any_match = 1'b0;
        any_free  = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_i[w]) begin
                match_way = WAY_W'(w);
                any_match = 1'b1;
            end
            if (!valid_i[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
    end

    // Final selection among the three candidates.
    always_comb begin
        use_rr_o = 1'b0;
        if (any_match) begin
            way_o = match_way;
        end else if (any_free) begin
            way_o = free_way;
        end else begin
            way_o    = rr_i;
            use_rr_o = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_entry_store.sv
// Entry storage with a read port for lookup and a write port for refill.
// Lookup is combinational. Refill and flush take effect on the clock edge.
// Assumes: SETS and WAYS are powers of two; flush overrides refill.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int VPN_W = 8,
    parameter int PPN_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = VPN_W - SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output tlb_perm_t        lk_perm,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  tlb_perm_t        fill_perm
);

    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn_q;
    tlb_perm_t [SETS-1:0][WAYS-1:0]       perm_q;
    logic [SETS-1:0][WAY_W-1:0]           rr_q;

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [SET_W-1:0] fill_set;
    logic [TAG_W-1:0] fill_tag;
    logic [WAYS-1:0]  way_hit;
    logic [WAYS-1:0]  fill_match;
    logic [WAY_W-1:0] fill_way;
    logic             fill_use_rr;
    logic             fill_go;

    assign lk_set   = lk_vpn[SET_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:SET_W];
    assign fill_set = fill_vpn[SET_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:SET_W];
    assign fill_go  = fill_en && !flush;

    // One tag comparator per way for lookup and one per way for refill.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w]    = valid_q[lk_set][w]   && (tag_q[lk_set][w]   == lk_tag);
        assign fill_match[w] = valid_q[fill_set][w] && (tag_q[fill_set][w] == fill_tag);
    end

    // OR-mux of the (at most one) hitting way.
    always_comb begin
        lk_ppn  = '0;
        lk_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                lk_ppn  = lk_ppn  | ppn_q[lk_set][w];
                lk_perm = lk_perm | perm_q[lk_set][w];
            end
        end
    end
    assign lk_hit = |way_hit;

    tlb_way_pick #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_pick (
        .valid_i  (valid_q[fill_set]),
        .match_i  (fill_match),
        .rr_i     (rr_q[fill_set]),
        .way_o    (fill_way),
        .use_rr_o (fill_use_rr)
    );

    // Valid bits and round-robin pointers: reset, flush, refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_set][fill_way] <= 1'b1;
            if (fill_use_rr) begin
                rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
            end
        end
    end

    // Entry payload, written only by an accepted refill.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[fill_set][fill_way]  <= fill_tag;
            ppn_q[fill_set][fill_way]  <= fill_ppn;
            perm_q[fill_set][fill_way] <= fill_perm;
        end
    end

    // R3: a VPN never sits in two ways of its set.
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R7: one flush edge leaves no valid entry.
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R6: an accepted refill leaves its set with a valid entry.
    assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> (valid_q[$past(fill_set)] != '0));

endmodule

// File: rtl/tlb_req_ctrl.sv
// Request sequencing: resolves requests against the store, holds a missed
// request until a refill is accepted, then replays it once.
// Assumes: the store answers lookups combinationally in the same cycle.
module tlb_req_ctrl
    import tlb_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             refill_valid,
    output logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    input  tlb_perm_t        lk_perm,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  pa,
    output logic             miss
);

    tlb_state_e      state_q;
    logic [VA_W-1:0] held_va_q;
    logic            held_wr_q;
    logic [VA_W-1:0] lk_va;
    logic            lk_wr;
    logic            resolve;
    logic            denied;
    logic            refill_ok;

    // Replays use the held request; otherwise the live one is looked up.
    assign lk_va     = (state_q == ST_REPLAY) ? held_va_q : req_va;
    assign lk_wr     = (state_q == ST_REPLAY) ? held_wr_q : req_write;
    assign lk_vpn    = lk_va[VA_W-1:OFF_W];
    assign denied    = lk_wr ? !lk_perm.wr : !lk_perm.rd;
    assign resolve   = ((state_q == ST_IDLE) && req_valid) || (state_q == ST_REPLAY);
    assign refill_ok = refill_valid && !flush;

    // State, held request and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_va_q <= '0;
            held_wr_q <= 1'b0;
            done      <= 1'b0;
            fault     <= 1'b0;
            pa        <= '0;
            miss      <= 1'b0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            pa    <= '0;
            if ((state_q == ST_IDLE) && req_valid) begin
                held_va_q <= req_va;
                held_wr_q <= req_write;
            end
            if (resolve) begin
                if (lk_hit) begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                    if (denied) begin
                        fault <= 1'b1;
                    end else begin
                        pa <= {lk_ppn, lk_va[OFF_W-1:0]};
                    end
                end else begin
                    miss    <= 1'b1;
                    state_q <= ST_WAIT;
                end
            end else if ((state_q == ST_WAIT) && refill_ok) begin
                miss    <= 1'b0;
                state_q <= ST_REPLAY;
            end
        end
    end

    // R2: an idle request is answered on the next edge, by exactly one flag.
    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && req_valid) |=> (done ^ miss));

    // R5: without an accepted refill, a miss stays outstanding.
    assert_miss_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !refill_ok) |=> miss);

    // R5: an accepted refill clears the miss with no answer in that cycle.
    assert_refill_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && refill_ok) |=> (!miss && !done));

    // R5: no answer is given while a miss is outstanding.
    assert_no_done_in_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && miss));

    // R4: a fault always comes with done and a zero address.
    assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && (pa == '0)));

endmodule

// File: rtl/tlb_xlate.sv
// Top of the set-associative translation buffer: joins the request
// controller and the entry store, and maps plain ports to shared types.
// Assumes: refill_vpn carries the full VPN of the translation.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6,
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    output logic             resp_done,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_pa,
    output logic             resp_miss,
    input  logic             refill_valid,
    input  logic [VPN_W-1:0] refill_vpn,
    input  logic [PPN_W-1:0] refill_ppn,
    input  logic             refill_rd,
    input  logic             refill_wr
);

    logic [VPN_W-1:0] lk_vpn;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    tlb_perm_t        lk_perm;
    tlb_perm_t        fill_perm;

    // Pack the refill rights into the shared type.
    assign fill_perm = '{rd: refill_rd, wr: refill_wr};

    tlb_req_ctrl #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .req_valid    (req_valid),
        .req_va       (req_va),
        .req_write    (req_write),
        .refill_valid (refill_valid),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_ppn       (lk_ppn),
        .lk_perm      (lk_perm),
        .done         (resp_done),
        .fault        (resp_fault),
        .pa           (resp_pa),
        .miss         (resp_miss)
    );

    tlb_entry_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (lk_vpn),
        .lk_hit    (lk_hit),
        .lk_ppn    (lk_ppn),
        .lk_perm   (lk_perm),
        .fill_en   (refill_valid),
        .fill_vpn  (refill_vpn),
        .fill_ppn  (refill_ppn),
        .fill_perm (fill_perm)
    );

    // R1: the page offset of a hit passes through unchanged.
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!resp_miss && req_valid && lk_hit && (req_write ? lk_perm.wr : lk_perm.rd))
        |=> (resp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        resp_done;
    logic        resp_fault;
    logic [11:0] resp_pa;
    logic        resp_miss;
    logic        refill_valid = 1'b0;
    logic [7:0]  refill_vpn = '0;
    logic [5:0]  refill_ppn = '0;
    logic        refill_rd = 1'b0;
    logic        refill_wr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .resp_done(resp_done), .resp_fault(resp_fault),
        .resp_pa(resp_pa), .resp_miss(resp_miss),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_rd(refill_rd), .refill_wr(refill_wr)
    );

    typedef struct packed {
        logic [13:0] va;
        logic        wr;
        logic        flt;
        logic [11:0] pa;
    } vec_t;

    // Hits on preloaded entries: 0x0F->0x0D read-only, 0x00->0x28 rw, 0x04->0x11 write-only.
    localparam vec_t VEC [7] = '{
        '{va: 14'h03D4, wr: 1'b0, flt: 1'b0, pa: 12'h354},
        '{va: 14'h03D4, wr: 1'b1, flt: 1'b1, pa: 12'h000},
        '{va: 14'h003F, wr: 1'b0, flt: 1'b0, pa: 12'hA3F},
        '{va: 14'h0011, wr: 1'b1, flt: 1'b0, pa: 12'hA11},
        '{va: 14'h0105, wr: 1'b0, flt: 1'b1, pa: 12'h000},
        '{va: 14'h0120, wr: 1'b1, flt: 1'b0, pa: 12'h460},
        '{va: 14'h03FF, wr: 1'b0, flt: 1'b0, pa: 12'h37F}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic done, input logic flt,
                              input logic [11:0] pa, input logic miss);
        chk({tag, " done"}, 32'(resp_done), 32'(done));
        chk({tag, " fault"}, 32'(resp_fault), 32'(flt));
        chk({tag, " miss"}, 32'(resp_miss), 32'(miss));
        if (done && !flt) chk({tag, " pa"}, 32'(resp_pa), 32'(pa));
    endtask

    task automatic send_req(input logic [13:0] va, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_refill(input logic [7:0] vpn, input logic [5:0] ppn,
                               input logic rd, input logic wr, input logic fl);
        @(negedge clk);
        refill_valid = 1'b1; refill_vpn = vpn; refill_ppn = ppn;
        refill_rd = rd; refill_wr = wr; flush = fl;
        @(posedge clk);
        @(negedge clk);
        refill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic send_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Refill while a miss waits, then check release and the replayed answer.
    task automatic refill_release(input string tag, input logic [7:0] vpn, input logic [5:0] ppn,
                                  input logic [11:0] pa);
        send_refill(vpn, ppn, 1'b1, 1'b1, 1'b0);
        expect_out({tag, " R5 release"}, 1'b0, 1'b0, 12'h0, 1'b0);
        @(negedge clk);
        expect_out({tag, " R5 replay"}, 1'b1, 1'b0, pa, 1'b0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R8: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_out("R8 reset", 1'b0, 1'b0, 12'h0, 1'b0);
        chk("R8 reset pa", 32'(resp_pa), 32'h0);
        rst_n = 1'b1;

        // R8/R3: empty table misses; R5/R1: refill then replay gives 0x354.
        send_req(14'h03D4, 1'b0);
        expect_out("R8 R3 empty miss", 1'b0, 1'b0, 12'h0, 1'b1);
        send_refill(8'h0F, 6'h0D, 1'b1, 1'b0, 1'b0);
        expect_out("R5 first release", 1'b0, 1'b0, 12'h0, 1'b0);
        @(negedge clk);
        expect_out("R1 R5 first replay", 1'b1, 1'b0, 12'h354, 1'b0);

        // Preload further entries (idle refills give no answer).
        send_refill(8'h00, 6'h28, 1'b1, 1'b1, 1'b0);
        send_refill(8'h04, 6'h11, 1'b0, 1'b1, 1'b0);
        expect_out("R6 idle refill silent", 1'b0, 1'b0, 12'h0, 1'b0);

        // R1 R2 R4: vector table.
        for (int i = 0; i < 7; i++) begin
            send_req(VEC[i].va, VEC[i].wr);
            expect_out($sformatf("R1 R2 R4 vec%0d", i), 1'b1, VEC[i].flt, VEC[i].pa, 1'b0);
        end

        // R3: same set, other tag misses; R5: request during a miss is ignored.
        send_req(14'h07C5, 1'b0);
        expect_out("R3 tag mismatch", 1'b0, 1'b0, 12'h0, 1'b1);
        send_req(14'h03D4, 1'b0);
        expect_out("R5 ignored req", 1'b0, 1'b0, 12'h0, 1'b1);
        refill_release("hold", 8'h1F, 6'h3A, 12'hE85);
        @(negedge clk);
        expect_out("R5 no late answer", 1'b0, 1'b0, 12'h0, 1'b0);

        // R6: refill of a present VPN updates that entry in place.
        send_refill(8'h0F, 6'h0E, 1'b1, 1'b1, 1'b0);
        send_req(14'h03D4, 1'b1);
        expect_out("R6 in-place update", 1'b1, 1'b0, 12'h394, 1'b0);
        send_req(14'h07C5, 1'b0);
        expect_out("R6 neighbour kept", 1'b1, 1'b0, 12'hE85, 1'b0);

        // R6: fill set 1 by free ways, then round-robin from way 0.
        send_refill(8'h01, 6'h21, 1'b1, 1'b1, 1'b0);
        send_refill(8'h05, 6'h25, 1'b1, 1'b1, 1'b0);
        send_refill(8'h09, 6'h29, 1'b1, 1'b1, 1'b0);
        send_refill(8'h0D, 6'h2D, 1'b1, 1'b1, 1'b0);
        send_refill(8'h11, 6'h31, 1'b1, 1'b1, 1'b0);
        send_req(14'h0140, 1'b0);
        expect_out("R6 way1 kept", 1'b1, 1'b0, 12'h940, 1'b0);
        send_req(14'h0440, 1'b0);
        expect_out("R6 new entry", 1'b1, 1'b0, 12'hC40, 1'b0);
        send_req(14'h0040, 1'b0);
        expect_out("R6 way0 evicted", 1'b0, 1'b0, 12'h0, 1'b1);
        refill_release("R6 rr1", 8'h01, 6'h21, 12'h840);
        send_req(14'h0140, 1'b0);
        expect_out("R6 way1 evicted", 1'b0, 1'b0, 12'h0, 1'b1);
        refill_release("R6 rr2", 8'h05, 6'h25, 12'h940);
        send_req(14'h0340, 1'b0);
        expect_out("R6 way3 kept", 1'b1, 1'b0, 12'hB40, 1'b0);
        send_req(14'h0240, 1'b0);
        expect_out("R6 way2 evicted", 1'b0, 1'b0, 12'h0, 1'b1);
        refill_release("R6 rr3", 8'h09, 6'h29, 12'hA40);

        // R7: flush empties the table; refill with flush is dropped.
        send_flush();
        send_req(14'h03D4, 1'b0);
        expect_out("R7 flushed miss", 1'b0, 1'b0, 12'h0, 1'b1);
        send_refill(8'h0F, 6'h0D, 1'b1, 1'b1, 1'b1);
        expect_out("R7 refill dropped", 1'b0, 1'b0, 12'h0, 1'b1);
        refill_release("R7 after flush", 8'h0F, 6'h0D, 12'h354);
        send_req(14'h003F, 1'b0);
        expect_out("R7 other gone", 1'b0, 1'b0, 12'h0, 1'b1);
        refill_release("R7 restore", 8'h00, 6'h28, 12'hA3F);

        finish_run();
    end

endmodule